// File: doc/BRIEF.md
# RTC Sleep Wakeup Comparator

This block keeps a board asleep until a real-time count reaches a programmed wake time. A host writes a byte-wide register port. The port holds a control register, a 32-bit wake time and a 32-bit additive value. The two 32-bit values are each spread over four byte locations, with the least significant byte at the lowest address. The free-running RTC count comes in as an input, and the block compares it against the stored wake time on every cycle.

Sleep begins when the host sets both the enable bit and the activate bit. The `asleep` output then stays high until one of two events ends it. The first is the RTC count reaching or passing the wake time. The second is a pushbutton press, if the control register does not block button wake. On wake, the hardware clears the activate bit and pulses `wake_pulse` for one cycle. It also sets the reported wake cause to the sleep-wake code.

A self-clearing latch command loads the wake time with the current RTC count plus the additive value. This lets software program a relative delay without reading the clock first.

Top module: `rtc_wake_cmp`

## Requirements
- R1: Address 0 is the control register. Addresses 1..4 hold the wake time and addresses 5..8 hold the additive value, each least significant byte first. The `wake_time` output shows the stored wake time.
- R2: The control bits are: bit 0 sleep enable, bit 1 activate sleep, bit 2 latch command, bit 3 block button wake. `ctl_q` shows them, and bits 7:4 read as zero.
- R3: `asleep` is high exactly when control bits 0 and 1 are both set. Either bit alone does not put the block to sleep.
- R4: While asleep, a wake happens at the clock edge after `rtc_count` is greater than or equal to `wake_time`. The comparison is unsigned.
- R5: While asleep with control bit 3 clear, a high `button_press` causes a wake at the next edge. With bit 3 set, the button is ignored.
- R6: A wake pulses `wake_pulse` high for exactly one cycle and clears control bit 1, so `asleep` is low in the same cycle as the pulse.
- R7: `wake_cause` is 0 after reset and becomes 6 at the first wake.
- R8: Writing control bit 2 sets it for one cycle. At the following edge, `wake_time` becomes `rtc_count` plus the additive value, modulo 2^32, and bit 2 reads back as 0.
- R9: `wake_pulse` never rises while the block is not asleep, even when `rtc_count` is at or past `wake_time`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register byte address |
| wr_data | input | 8 | Register write data |
| rtc_count | input | 32 | Free-running RTC count |
| button_press | input | 1 | Pushbutton pressed (level) |
| ctl_q | output | 8 | Control register readback |
| wake_time | output | 32 | Stored wake time |
| asleep | output | 1 | Board held in sleep |
| wake_pulse | output | 1 | One-cycle wake event |
| wake_cause | output | 4 | Reset-cause code, 6 after a sleep wake |

## Verification
The hardest situations to reach are the edges of the comparison. One is an RTC count exactly one below the wake time, which must not wake. Another is a count whose top bit is set against a wake time whose top bit is clear, which must wake under unsigned comparison. The bench holds `rtc_count` fixed at each value across several cycles and moves it by hand to these points. The latch command's wrap past 2^32 is reached the same way, by pinning the count just below its maximum before issuing the command.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;
  localparam int TIME_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int CAUSE_W = 4;
  localparam int CTL_W   = 4;

  // control bit positions
  localparam int CTL_EN    = 0;
  localparam int CTL_GO    = 1;
  localparam int CTL_LATCH = 2;
  localparam int CTL_NOBTN = 3;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE  = CAUSE_W'(0);
  localparam logic [CAUSE_W-1:0] CAUSE_SLEEP = CAUSE_W'(6);

  // unsigned "reached" test
  function automatic logic time_reached(input logic [TIME_W-1:0] now,
                                        input logic [TIME_W-1:0] target);
    return now >= target;
  endfunction

  // modular sum for the latch command
  function automatic logic [TIME_W-1:0] time_after(input logic [TIME_W-1:0] now,
                                                   input logic [TIME_W-1:0] delta);
    return now + delta;
  endfunction
endpackage

// File: rtl/rtc_wake_regs.sv
module rtc_wake_regs
  import rtc_wake_pkg::*;
#(
  parameter int TW = TIME_W,
  parameter int AW = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [TW-1:0]     rtc_count,
  input  logic              wake_fire,
  output logic [CTL_W-1:0]  ctl,
  output logic [TW-1:0]     wake_time,
  output logic [TW-1:0]     add_val
);
  localparam int NBYTES    = TW / BYTE_W;
  localparam int CTL_ADDR  = 0;
  localparam int WAKE_BASE = 1;
  localparam int ADD_BASE  = WAKE_BASE + NBYTES;

  logic           ctl_hit;
  logic [TW-1:0]  latch_sum;

  assign ctl_hit   = wr_en && (wr_addr == AW'(CTL_ADDR));
  assign latch_sum = time_after(rtc_count, add_val);

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (ctl_hit) begin
        ctl[CTL_EN]    <= wr_data[CTL_EN];
        ctl[CTL_NOBTN] <= wr_data[CTL_NOBTN];
      end
      // latch bit: one cycle, then self-clear
      ctl[CTL_LATCH] <= ctl_hit && wr_data[CTL_LATCH];
      // activate bit: hardware wake clear wins over a host write
      if (wake_fire)    ctl[CTL_GO] <= 1'b0;
      else if (ctl_hit) ctl[CTL_GO] <= wr_data[CTL_GO];
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wake_time[i*BYTE_W +: BYTE_W] <= '0;
      end else if (ctl[CTL_LATCH]) begin
        wake_time[i*BYTE_W +: BYTE_W] <= latch_sum[i*BYTE_W +: BYTE_W];
      end else if (wr_en && wr_addr == AW'(WAKE_BASE + i)) begin
        wake_time[i*BYTE_W +: BYTE_W] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        add_val[i*BYTE_W +: BYTE_W] <= '0;
      end else if (wr_en && wr_addr == AW'(ADD_BASE + i)) begin
        add_val[i*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rtc_wake_detect.sv
module rtc_wake_detect
  import rtc_wake_pkg::*;
#(
  parameter int TW = TIME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               asleep,
  input  logic [TW-1:0]      rtc_count,
  input  logic [TW-1:0]      wake_time,
  input  logic               button_press,
  input  logic               button_block,
  output logic               wake_fire,
  output logic               wake_pulse,
  output logic [CAUSE_W-1:0] wake_cause
);
  logic time_hit;
  logic btn_hit;

  assign time_hit  = time_reached(rtc_count, wake_time);
  assign btn_hit   = button_press && !button_block;
  assign wake_fire = asleep && (time_hit || btn_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_pulse <= 1'b0;
      wake_cause <= CAUSE_NONE;
    end else begin
      wake_pulse <= wake_fire;
      if (wake_fire) wake_cause <= CAUSE_SLEEP;
    end
  end
endmodule

// File: rtl/rtc_wake_cmp.sv
module rtc_wake_cmp
  import rtc_wake_pkg::*;
#(
  parameter int TW = TIME_W,
  parameter int AW = ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [TW-1:0]      rtc_count,
  input  logic               button_press,
  output logic [BYTE_W-1:0]  ctl_q,
  output logic [TW-1:0]      wake_time,
  output logic               asleep,
  output logic               wake_pulse,
  output logic [CAUSE_W-1:0] wake_cause
);
  logic [CTL_W-1:0] ctl;
  logic [TW-1:0]    add_val;
  logic             wake_fire;

  rtc_wake_regs #(.TW(TW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rtc_count (rtc_count),
    .wake_fire (wake_fire),
    .ctl       (ctl),
    .wake_time (wake_time),
    .add_val   (add_val)
  );

  assign asleep = ctl[CTL_EN] && ctl[CTL_GO];
  assign ctl_q  = {{(BYTE_W-CTL_W){1'b0}}, ctl};

  rtc_wake_detect #(.TW(TW)) u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .asleep       (asleep),
    .rtc_count    (rtc_count),
    .wake_time    (wake_time),
    .button_press (button_press),
    .button_block (ctl[CTL_NOBTN]),
    .wake_fire    (wake_fire),
    .wake_pulse   (wake_pulse),
    .wake_cause   (wake_cause)
  );
endmodule

// File: rtl/rtc_wake_chk.sv
module rtc_wake_chk
  import rtc_wake_pkg::*;
#(
  parameter int TW = TIME_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [BYTE_W-1:0]  ctl_q,
  input logic               asleep,
  input logic               wake_pulse,
  input logic [CAUSE_W-1:0] wake_cause,
  input logic [TW-1:0]      rtc_count,
  input logic [TW-1:0]      wake_time,
  input logic [TW-1:0]      add_val
);
  a_r4_due_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && (rtc_count >= wake_time) |=> wake_pulse);

  a_r6_pulse_ends_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> !asleep && !ctl_q[CTL_GO]);

  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  a_r9_pulse_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(asleep));

  a_r7_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> wake_cause == CAUSE_SLEEP);

  a_r8_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CTL_LATCH] && !wr_en |=> !ctl_q[CTL_LATCH]);

  a_r8_latch_value: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CTL_LATCH] |=> wake_time == TW'($past(rtc_count) + $past(add_val)));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[BYTE_W-1:CTL_W] == '0);
endmodule

bind rtc_wake_cmp rtc_wake_chk #(.TW(TW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .ctl_q      (ctl_q),
  .asleep     (asleep),
  .wake_pulse (wake_pulse),
  .wake_cause (wake_cause),
  .rtc_count  (rtc_count),
  .wake_time  (wake_time),
  .add_val    (add_val)
);

// File: tb/test_rtc_wake_cmp.sv
`timescale 1ns/1ps
module test_rtc_wake_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [31:0] rtc_count = '0;
  logic        button_press = 1'b0;
  logic [7:0]  ctl_q;
  logic [31:0] wake_time;
  logic        asleep;
  logic        wake_pulse;
  logic [3:0]  wake_cause;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  rtc_wake_cmp i_rtc_wake_cmp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rtc_count(rtc_count), .button_press(button_press),
    .ctl_q(ctl_q), .wake_time(wake_time), .asleep(asleep),
    .wake_pulse(wake_pulse), .wake_cause(wake_cause)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one write, ends at the negedge after the capturing edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_word(input logic [3:0] base, input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(base + 4'(i), v[i*8 +: 8]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R7 reset cause", 32'(wake_cause), 32'd0);
    check("R3 reset asleep", 32'(asleep), 32'd0);
    check("R6 reset pulse", 32'(wake_pulse), 32'd0);
    check("R1 reset wake time", wake_time, 32'd0);
  endtask

  task automatic t_byte_order;
    set_word(4'd1, 32'h44332211);
    check("R1 wake bytes lsb first", wake_time, 32'h44332211);
    wr(4'd0, 8'hF0);
    check("R2 upper ctl bits zero", 32'(ctl_q), 32'h0);
  endtask

  task automatic t_need_both;
    set_word(4'd1, 32'h0000_1000);
    rtc_count = 32'h0000_0FFF;
    wr(4'd0, 8'h01);
    check("R3 enable only", 32'(asleep), 32'd0);
    wr(4'd0, 8'h02);
    check("R3 activate only", 32'(asleep), 32'd0);
    wr(4'd0, 8'h00);
  endtask

  task automatic t_time_wake;
    rtc_count = 32'h0000_0FFF;
    wr(4'd0, 8'h03);
    check("R3 both set sleeps", 32'(asleep), 32'd1);
    idle(3);
    check("R4 one below holds", 32'(asleep), 32'd1);
    check("R4 no early pulse", 32'(wake_pulse), 32'd0);
    rtc_count = 32'h0000_1000;
    @(negedge clk);
    check("R6 pulse on wake", 32'(wake_pulse), 32'd1);
    check("R6 asleep low", 32'(asleep), 32'd0);
    check("R6 activate cleared", 32'(ctl_q), 32'h01);
    check("R7 cause six", 32'(wake_cause), 32'd6);
    @(negedge clk);
    check("R6 pulse one cycle", 32'(wake_pulse), 32'd0);
    idle(3);
    check("R9 no pulse while awake", 32'(wake_pulse), 32'd0);
  endtask

  task automatic t_unsigned;
    set_word(4'd1, 32'h7FFF_FFFF);
    rtc_count = 32'h8000_0000;
    wr(4'd0, 8'h03);
    check("R4 unsigned asleep first", 32'(asleep), 32'd1);
    @(negedge clk);
    check("R4 unsigned past wakes", 32'(wake_pulse), 32'd1);
    idle(2);
  endtask

  task automatic t_button_allowed;
    set_word(4'd1, 32'hFFFF_FFFF);
    rtc_count = 32'h10;
    wr(4'd0, 8'h03);
    button_press = 1'b1;
    @(negedge clk);
    button_press = 1'b0;
    check("R5 button wakes", 32'(wake_pulse), 32'd1);
    check("R5 asleep cleared", 32'(asleep), 32'd0);
    idle(2);
  endtask

  task automatic t_button_blocked;
    rtc_count = 32'h10;
    wr(4'd0, 8'h0B);
    button_press = 1'b1;
    idle(3);
    button_press = 1'b0;
    check("R5 button ignored asleep", 32'(asleep), 32'd1);
    check("R5 button ignored pulse", 32'(wake_pulse), 32'd0);
    rtc_count = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R5 blocked still wakes on time", 32'(wake_pulse), 32'd1);
    idle(2);
    wr(4'd0, 8'h00);
  endtask

  task automatic t_latch(input logic [31:0] now, input logic [31:0] delta);
    set_word(4'd5, delta);
    rtc_count = now;
    wr(4'd0, 8'h04);
    check("R8 latch bit visible", 32'(ctl_q), 32'h04);
    @(negedge clk);
    check("R8 wake = rtc + add", wake_time, now + delta);
    check("R8 latch self cleared", 32'(ctl_q), 32'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(2);
    t_byte_order;
    t_need_both;
    t_time_wake;
    t_unsigned;
    t_button_allowed;
    t_button_blocked;
    t_latch(32'h0000_1000, 32'h0000_0100);
    t_latch(32'hFFFF_FFF0, 32'h0000_0020);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule